// File: doc/BRIEF.md
# Memory Expansion Request Controller with Per-Line Metadata

This block is the request handler inside a memory-expansion device. It takes read and write requests for 64-byte lines from a host port and drives a simple media port that stores each line together with a small metadata tag. The controller never interprets the tag. It stores the tag and returns it, and a read can ask for the stored tag to be replaced.

Writes go into a small write buffer and complete to the host on the next cycle. The media acknowledgement is not awaited. A read whose address matches a buffered, unacknowledged write is answered from the youngest matching entry, so a completed write is always visible to later reads. A read that misses the buffer issues one media read. When that read asks for a tag change, the old data and old tag go back to the host as soon as the media answers, and a write of the same data with the new tag is then queued through the write buffer. Responses come back in request order. At most `DEPTH` requests are in flight, counting buffered writes plus one outstanding media read.

Top module: `memx_req_ctrl`

## Requirements
- R1: After reset, `h_rsp_valid` and `m_cmd_valid` are 0 and `h_req_ready` is 1.
- R2: An accepted write (`h_req_wr`=1) yields a completion (`h_rsp_valid`=1, `h_rsp_wr`=1) in the cycle after acceptance, before the media acknowledges it.
- R3: Every accepted write reaches the media as one write command (`m_cmd_wr`=1) with its address, data and metadata. Buffered writes are issued in acceptance order.
- R4: A read with `h_req_upd_meta`=0 that matches no buffered write issues exactly one media read (`m_cmd_wr`=0) and no media write. It returns the media data and stored metadata together, one cycle after `m_rd_valid`.
- R5: A read with `h_req_upd_meta`≠0 returns the old data and old metadata. It then causes one media write of that same data to that address, with metadata equal to `h_req_upd_meta`.
- R6: A read to an address with a buffered, unacknowledged write is answered in the cycle after acceptance with the youngest such write's data and metadata, and issues no media read.
- R7: Buffered writes plus an outstanding media read never exceed `DEPTH`. `h_req_ready` is 0 while the buffer is full or a media read is outstanding.
- R8: Each request gets exactly one response, and responses come in request order.
- R9: Any `META_W`-bit metadata value written, including 0 and all-ones, is returned unchanged by a later read.
- R10: With `RD_FIRST`=1, when a media read and a buffered write both wait for the media port, the read is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request present |
| h_req_ready | output | 1 | Controller accepts the request this cycle |
| h_req_wr | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | ADDR_W | Line address |
| h_req_data | input | DATA_W | Write data |
| h_req_meta | input | META_W | Metadata stored with a write |
| h_req_upd_meta | input | META_W | Read only: new metadata to store, 0 = keep stored value |
| h_rsp_valid | output | 1 | Response present for one cycle |
| h_rsp_wr | output | 1 | 1 = write completion, 0 = read data |
| h_rsp_data | output | DATA_W | Read data (0 on write completion) |
| h_rsp_meta | output | META_W | Metadata read (0 on write completion) |
| m_cmd_valid | output | 1 | Media command present |
| m_cmd_ready | input | 1 | Media takes the command |
| m_cmd_wr | output | 1 | 1 = media write, 0 = media read |
| m_cmd_addr | output | ADDR_W | Media line address |
| m_cmd_data | output | DATA_W | Media write data |
| m_cmd_meta | output | META_W | Media write metadata |
| m_rd_valid | input | 1 | Media read data returned (in command order) |
| m_rd_data | input | DATA_W | Media read data |
| m_rd_meta | input | META_W | Media stored metadata |
| m_wr_ack | input | 1 | Media acknowledges the oldest issued write |

## Verification
Assertions check several rules on every cycle: the next-cycle completion after an accepted write, the next-cycle response after a buffer hit or a media read return, the media command staying offered until taken, the in-flight bound, write-buffer overflow, and that an acknowledgement only arrives for an issued write. The bench scenarios cover the behaviours that depend on what the media stored over time. These are the tag changes that reach the media after a read, the youngest of several same-address writes winning, reads served without touching the media, the issue order of reads and writes, and the order of responses across mixed request streams against a slow, stalling media model.

// File: rtl/memx_pkg.sv
package memx_pkg;
   localparam int unsigned LINE_BYTES = 64;

   typedef enum logic {
      CMD_RD = 1'b0,
      CMD_WR = 1'b1
   } cmd_kind_e;
endpackage

// File: rtl/memx_wbuf.sv
module memx_wbuf #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 512,
   parameter int META_W = 2,
   parameter int CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [DATA_W-1:0] alloc_data,
   input  logic [META_W-1:0] alloc_meta,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              look_hit,
   output logic [DATA_W-1:0] look_data,
   output logic [META_W-1:0] look_meta,
   output logic              iss_valid,
   output logic [ADDR_W-1:0] iss_addr,
   output logic [DATA_W-1:0] iss_data,
   output logic [META_W-1:0] iss_meta,
   input  logic              iss_take,
   input  logic              ack,
   output logic [CNT_W-1:0]  used
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic [META_W-1:0] e_meta [DEPTH];
   logic [DEPTH-1:0]  e_vld;
   logic [DEPTH-1:0]  slot_hit;
   logic [PTR_W-1:0]  hd_p, is_p, tl_p;
   logic [CNT_W-1:0]  n_used, n_wait;

   // per-slot address comparators
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign slot_hit[g] = e_vld[g] && (e_addr[g] == look_addr);
   end

   // scan oldest to youngest so that the youngest match wins
   always_comb begin
      logic [PTR_W-1:0] idx;
      look_hit  = 1'b0;
      look_data = '0;
      look_meta = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = hd_p + PTR_W'(k);
         if (slot_hit[idx]) begin
            look_hit  = 1'b1;
            look_data = e_data[idx];
            look_meta = e_meta[idx];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_en) begin
         e_addr[tl_p] <= alloc_addr;
         e_data[tl_p] <= alloc_data;
         e_meta[tl_p] <= alloc_meta;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_vld  <= '0;
         hd_p   <= '0;
         is_p   <= '0;
         tl_p   <= '0;
         n_used <= '0;
         n_wait <= '0;
      end else begin
         if (ack) begin
            e_vld[hd_p] <= 1'b0;
            hd_p        <= hd_p + 1'b1;
         end
         if (alloc_en) begin
            e_vld[tl_p] <= 1'b1;
            tl_p        <= tl_p + 1'b1;
         end
         if (iss_take) is_p <= is_p + 1'b1;
         n_used <= n_used + CNT_W'(alloc_en) - CNT_W'(ack);
         n_wait <= n_wait + CNT_W'(alloc_en) - CNT_W'(iss_take);
      end
   end

   assign iss_valid = (n_wait != '0);
   assign iss_addr  = e_addr[is_p];
   assign iss_data  = e_data[is_p];
   assign iss_meta  = e_meta[is_p];
   assign used      = n_used;

   // R7: a new entry is only written into a free slot
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (n_used < CNT_W'(DEPTH)));
   // R3: the media only acknowledges writes that were issued to it
   a_r3_ack_issued: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (n_used != n_wait));
   // R3: an entry is handed to the media at most once
   a_r3_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
      iss_take |-> (n_wait != '0));
endmodule

// File: rtl/memx_media_arb.sv
module memx_media_arb
   import memx_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 512,
   parameter int META_W   = 2,
   parameter bit RD_FIRST = 1'b1
) (
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [META_W-1:0] wr_meta,
   input  logic              cmd_ready,
   output logic              cmd_valid,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [META_W-1:0] cmd_meta,
   output logic              rd_take,
   output logic              wr_take
);
   cmd_kind_e sel;

   if (RD_FIRST) begin : g_rd_first
      always_comb sel = rd_req ? CMD_RD : CMD_WR;
   end else begin : g_wr_first
      always_comb sel = wr_req ? CMD_WR : CMD_RD;
   end

   assign cmd_valid = rd_req | wr_req;
   assign cmd_wr    = (sel == CMD_WR);
   assign cmd_addr  = cmd_wr ? wr_addr : rd_addr;
   assign cmd_data  = cmd_wr ? wr_data : '0;
   assign cmd_meta  = cmd_wr ? wr_meta : '0;
   assign rd_take   = cmd_valid && cmd_ready && !cmd_wr;
   assign wr_take   = cmd_valid && cmd_ready && cmd_wr;
endmodule

// File: rtl/memx_req_ctrl.sv
module memx_req_ctrl
   import memx_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = LINE_BYTES * 8,
   parameter int META_W   = 2,
   parameter int DEPTH    = 4,
   parameter bit RD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req_valid,
   output logic              h_req_ready,
   input  logic              h_req_wr,
   input  logic [ADDR_W-1:0] h_req_addr,
   input  logic [DATA_W-1:0] h_req_data,
   input  logic [META_W-1:0] h_req_meta,
   input  logic [META_W-1:0] h_req_upd_meta,
   output logic              h_rsp_valid,
   output logic              h_rsp_wr,
   output logic [DATA_W-1:0] h_rsp_data,
   output logic [META_W-1:0] h_rsp_meta,
   output logic              m_cmd_valid,
   input  logic              m_cmd_ready,
   output logic              m_cmd_wr,
   output logic [ADDR_W-1:0] m_cmd_addr,
   output logic [DATA_W-1:0] m_cmd_data,
   output logic [META_W-1:0] m_cmd_meta,
   input  logic              m_rd_valid,
   input  logic [DATA_W-1:0] m_rd_data,
   input  logic [META_W-1:0] m_rd_meta,
   input  logic              m_wr_ack
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("memx_req_ctrl: DEPTH must be a power of two, at least 2");
   end
   if (META_W < 1 || ADDR_W < 1 || DATA_W < 8) begin : g_bad_width
      $error("memx_req_ctrl: META_W, ADDR_W and DATA_W out of range");
   end

   logic              acc, ret;
   logic              wb_hit;
   logic [DATA_W-1:0] wb_hit_data;
   logic [META_W-1:0] wb_hit_meta;
   logic              wb_iss_valid, wb_take;
   logic [ADDR_W-1:0] wb_iss_addr;
   logic [DATA_W-1:0] wb_iss_data;
   logic [META_W-1:0] wb_iss_meta;
   logic [CNT_W-1:0]  wb_used;
   logic              al_en;
   logic [ADDR_W-1:0] al_addr;
   logic [DATA_W-1:0] al_data;
   logic [META_W-1:0] al_meta;
   logic              rd_busy, rd_issued, rd_take;
   logic [ADDR_W-1:0] rd_addr;
   logic [META_W-1:0] rd_upd;

   assign h_req_ready = !rd_busy && (wb_used < CNT_W'(DEPTH));
   assign acc         = h_req_valid && h_req_ready;
   assign ret         = m_rd_valid && rd_busy && rd_issued;

   // write buffer entry source: host write, buffer-hit tag change, or media-read tag change
   always_comb begin
      al_en   = 1'b0;
      al_addr = h_req_addr;
      al_data = h_req_data;
      al_meta = h_req_meta;
      if (acc && h_req_wr) begin
         al_en = 1'b1;
      end else if (acc && wb_hit && (h_req_upd_meta != '0)) begin
         al_en   = 1'b1;
         al_data = wb_hit_data;
         al_meta = h_req_upd_meta;
      end else if (ret && (rd_upd != '0)) begin
         al_en   = 1'b1;
         al_addr = rd_addr;
         al_data = m_rd_data;
         al_meta = rd_upd;
      end
   end

   memx_wbuf #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .META_W(META_W),
      .CNT_W (CNT_W)
   ) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (al_en),
      .alloc_addr(al_addr),
      .alloc_data(al_data),
      .alloc_meta(al_meta),
      .look_addr (h_req_addr),
      .look_hit  (wb_hit),
      .look_data (wb_hit_data),
      .look_meta (wb_hit_meta),
      .iss_valid (wb_iss_valid),
      .iss_addr  (wb_iss_addr),
      .iss_data  (wb_iss_data),
      .iss_meta  (wb_iss_meta),
      .iss_take  (wb_take),
      .ack       (m_wr_ack),
      .used      (wb_used)
   );

   memx_media_arb #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .META_W  (META_W),
      .RD_FIRST(RD_FIRST)
   ) u_arb (
      .rd_req   (rd_busy && !rd_issued),
      .rd_addr  (rd_addr),
      .wr_req   (wb_iss_valid),
      .wr_addr  (wb_iss_addr),
      .wr_data  (wb_iss_data),
      .wr_meta  (wb_iss_meta),
      .cmd_ready(m_cmd_ready),
      .cmd_valid(m_cmd_valid),
      .cmd_wr   (m_cmd_wr),
      .cmd_addr (m_cmd_addr),
      .cmd_data (m_cmd_data),
      .cmd_meta (m_cmd_meta),
      .rd_take  (rd_take),
      .wr_take  (wb_take)
   );

   // single outstanding media read keeps responses in request order
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_busy   <= 1'b0;
         rd_issued <= 1'b0;
         rd_addr   <= '0;
         rd_upd    <= '0;
      end else begin
         if (acc && !h_req_wr && !wb_hit) begin
            rd_busy   <= 1'b1;
            rd_issued <= 1'b0;
            rd_addr   <= h_req_addr;
            rd_upd    <= h_req_upd_meta;
         end else if (ret) begin
            rd_busy   <= 1'b0;
            rd_issued <= 1'b0;
         end else if (rd_take) begin
            rd_issued <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_rsp_valid <= 1'b0;
         h_rsp_wr    <= 1'b0;
         h_rsp_data  <= '0;
         h_rsp_meta  <= '0;
      end else begin
         h_rsp_valid <= 1'b0;
         if (acc && h_req_wr) begin
            h_rsp_valid <= 1'b1;
            h_rsp_wr    <= 1'b1;
            h_rsp_data  <= '0;
            h_rsp_meta  <= '0;
         end else if (acc && wb_hit) begin
            h_rsp_valid <= 1'b1;
            h_rsp_wr    <= 1'b0;
            h_rsp_data  <= wb_hit_data;
            h_rsp_meta  <= wb_hit_meta;
         end else if (ret) begin
            h_rsp_valid <= 1'b1;
            h_rsp_wr    <= 1'b0;
            h_rsp_data  <= m_rd_data;
            h_rsp_meta  <= m_rd_meta;
         end
      end
   end

   // R2: early write completion on the next cycle
   a_r2_write_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && h_req_wr) |=> (h_rsp_valid && h_rsp_wr));
   // R6: buffer hit answered on the next cycle with buffered contents
   a_r6_fwd_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !h_req_wr && wb_hit) |=> (h_rsp_valid && !h_rsp_wr
                                        && h_rsp_meta == $past(wb_hit_meta)));
   // R4: media read data reaches the host one cycle later
   a_r4_media_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> (h_rsp_valid && !h_rsp_wr && h_rsp_meta == $past(m_rd_meta)));
   // R5: a tag change after a media read leaves an entry in the buffer
   a_r5_upd_queued: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && rd_upd != '0) |=> (wb_used != '0));
   // R3: a media command stays offered until taken
   a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_cmd_valid && !m_cmd_ready) |=> m_cmd_valid);
   // R7: buffered writes plus the outstanding read stay within DEPTH
   a_r7_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_used + CNT_W'(rd_busy)) <= CNT_W'(DEPTH));
   // R8: media read data only arrives for an issued read
   a_r8_rd_expected: assert property (@(posedge clk) disable iff (!rst_n)
      m_rd_valid |-> (rd_busy && rd_issued));
endmodule

// File: tb/memx_req_ctrl_bench.sv
module memx_req_ctrl_bench;
   localparam int AW = 16;
   localparam int DW = 512;
   localparam int MW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_req_valid = 1'b0, h_req_ready, h_req_wr = 1'b0;
   logic [AW-1:0] h_req_addr = '0;
   logic [DW-1:0] h_req_data = '0;
   logic [MW-1:0] h_req_meta = '0, h_req_upd_meta = '0;
   logic          h_rsp_valid, h_rsp_wr;
   logic [DW-1:0] h_rsp_data;
   logic [MW-1:0] h_rsp_meta;
   logic          m_cmd_valid, m_cmd_wr;
   logic          m_cmd_ready;
   logic [AW-1:0] m_cmd_addr;
   logic [DW-1:0] m_cmd_data;
   logic [MW-1:0] m_cmd_meta;
   logic          m_rd_valid = 1'b0, m_wr_ack = 1'b0;
   logic [DW-1:0] m_rd_data = '0;
   logic [MW-1:0] m_rd_meta = '0;

   always #5 clk = ~clk;

   memx_req_ctrl #(.ADDR_W(AW), .DATA_W(DW), .META_W(MW), .DEPTH(4)) u_memx_req_ctrl (
      .clk(clk), .rst_n(rst_n),
      .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_wr(h_req_wr),
      .h_req_addr(h_req_addr), .h_req_data(h_req_data), .h_req_meta(h_req_meta),
      .h_req_upd_meta(h_req_upd_meta),
      .h_rsp_valid(h_rsp_valid), .h_rsp_wr(h_rsp_wr), .h_rsp_data(h_rsp_data),
      .h_rsp_meta(h_rsp_meta),
      .m_cmd_valid(m_cmd_valid), .m_cmd_ready(m_cmd_ready), .m_cmd_wr(m_cmd_wr),
      .m_cmd_addr(m_cmd_addr), .m_cmd_data(m_cmd_data), .m_cmd_meta(m_cmd_meta),
      .m_rd_valid(m_rd_valid), .m_rd_data(m_rd_data), .m_rd_meta(m_rd_meta),
      .m_wr_ack(m_wr_ack)
   );

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mkd(input logic [31:0] s);
      return {16{s}};
   endfunction

   // ---------------- media model: in-order, variable latency ----------------
   logic [DW-1:0] mem_d [64];
   logic [MW-1:0] mem_m [64];
   logic          mq_wr [32];
   logic [AW-1:0] mq_a  [32];
   logic [DW-1:0] mq_d  [32];
   logic [MW-1:0] mq_m  [32];
   logic [4:0]    mq_h = '0, mq_t = '0;
   int            mwait = 0;
   int            med_lat = 2;
   bit            med_rdy = 1'b1;
   logic          cl_wr [256];
   logic [AW-1:0] cl_a  [256];
   logic [MW-1:0] cl_m  [256];
   int            ncmd = 0, nmrd = 0, nmwr = 0;

   assign m_cmd_ready = med_rdy;

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem_d[i] = mkd(32'hA000 + i);
         mem_m[i] = MW'(i % 4);
      end
   end

   always @(posedge clk) begin
      m_rd_valid <= 1'b0;
      m_wr_ack   <= 1'b0;
      if (rst_n && m_cmd_valid && m_cmd_ready) begin
         mq_wr[mq_t] <= m_cmd_wr;
         mq_a[mq_t]  <= m_cmd_addr;
         mq_d[mq_t]  <= m_cmd_data;
         mq_m[mq_t]  <= m_cmd_meta;
         mq_t        <= mq_t + 1'b1;
         cl_wr[ncmd % 256] <= m_cmd_wr;
         cl_a[ncmd % 256]  <= m_cmd_addr;
         cl_m[ncmd % 256]  <= m_cmd_meta;
         ncmd <= ncmd + 1;
         if (m_cmd_wr) nmwr <= nmwr + 1;
         else          nmrd <= nmrd + 1;
      end
      if (mq_h != mq_t) begin
         if (mwait < med_lat) mwait <= mwait + 1;
         else begin
            mwait <= 0;
            mq_h  <= mq_h + 1'b1;
            if (mq_wr[mq_h]) begin
               mem_d[mq_a[mq_h][5:0]] <= mq_d[mq_h];
               mem_m[mq_a[mq_h][5:0]] <= mq_m[mq_h];
               m_wr_ack <= 1'b1;
            end else begin
               m_rd_data  <= mem_d[mq_a[mq_h][5:0]];
               m_rd_meta  <= mem_m[mq_a[mq_h][5:0]];
               m_rd_valid <= 1'b1;
            end
         end
      end
   end

   // ---------------- response log ----------------
   logic          rl_wr [256];
   logic [31:0]   rl_d  [256];
   logic [MW-1:0] rl_m  [256];
   int            nrsp = 0;

   always @(negedge clk) begin
      if (h_rsp_valid) begin
         rl_wr[nrsp % 256] <= h_rsp_wr;
         rl_d[nrsp % 256]  <= h_rsp_data[31:0];
         rl_m[nrsp % 256]  <= h_rsp_meta;
         nrsp <= nrsp + 1;
      end
   end

   // ---------------- helpers ----------------
   // returns at the negedge right after the accepting edge
   task automatic send(input bit wr, input int a, input logic [DW-1:0] d,
                       input logic [MW-1:0] m, input logic [MW-1:0] nm);
      @(negedge clk);
      h_req_valid    = 1'b1;
      h_req_wr       = wr;
      h_req_addr     = AW'(a);
      h_req_data     = d;
      h_req_meta     = m;
      h_req_upd_meta = nm;
      while (!h_req_ready) @(negedge clk);
      @(negedge clk);
      h_req_valid = 1'b0;
   endtask

   task automatic wait_rsp(input int prev);
      while (nrsp <= prev) @(negedge clk);
   endtask

   task automatic drain();
      @(negedge clk);
      while (m_cmd_valid || (mq_h != mq_t)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(h_rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(h_rsp_valid), 0);
      chk(m_cmd_valid == 1'b0, "R1 cmd_valid after reset", 64'(m_cmd_valid), 0);
      chk(h_req_ready == 1'b1, "R1 ready after reset", 64'(h_req_ready), 1);
   endtask

   task automatic t_early_cpl_and_fwd();
      int rd0;
      med_lat = 20;
      send(1'b1, 3, mkd(32'h3333), 2'd2, 2'd0);
      chk(h_rsp_valid && h_rsp_wr, "R2 write completion next cycle",
          64'({h_rsp_valid, h_rsp_wr}), 64'b11);
      chk(mem_d[3][31:0] != 32'h3333, "R2 completion precedes media update",
          64'(mem_d[3][31:0]), 64'hA003);
      rd0 = nmrd;
      send(1'b0, 3, '0, 2'd0, 2'd0);
      chk(h_rsp_valid && !h_rsp_wr && h_rsp_data[31:0] == 32'h3333,
          "R6 buffered read data", 64'(h_rsp_data[31:0]), 64'h3333);
      chk(h_rsp_meta == 2'd2, "R6 buffered read meta", 64'(h_rsp_meta), 2);
      drain();
      chk(nmrd == rd0, "R6 no media read on hit", 64'(nmrd - rd0), 0);
      chk(mem_d[3][31:0] == 32'h3333 && mem_m[3] == 2'd2, "R3 write stored on media",
          64'({mem_m[3], mem_d[3][31:0]}), 64'h2_00003333);
   endtask

   task automatic t_read_plain();
      int w0, r0, p0;
      med_lat = 10;
      w0 = nmwr; r0 = nmrd; p0 = nrsp;
      send(1'b0, 5, '0, 2'd0, 2'd0);
      chk(h_req_ready == 1'b0, "R7 ready low during media read", 64'(h_req_ready), 0);
      wait_rsp(p0);
      chk(rl_d[p0 % 256] == 32'hA005 && rl_m[p0 % 256] == 2'd1 && !rl_wr[p0 % 256],
          "R4 read data and meta", 64'({rl_m[p0 % 256], rl_d[p0 % 256]}), 64'h1_0000A005);
      drain();
      chk(nmrd - r0 == 1, "R4 one media read", 64'(nmrd - r0), 1);
      chk(nmwr == w0, "R4 no media write", 64'(nmwr - w0), 0);
   endtask

   task automatic t_read_update();
      int p0, c0;
      med_lat = 4;
      p0 = nrsp; c0 = ncmd;
      send(1'b0, 6, '0, 2'd0, 2'd3);
      wait_rsp(p0);
      chk(rl_d[p0 % 256] == 32'hA006 && rl_m[p0 % 256] == 2'd2,
          "R5 old data and old meta returned", 64'({rl_m[p0 % 256], rl_d[p0 % 256]}),
          64'h2_0000A006);
      drain();
      chk(ncmd - c0 == 2 && cl_wr[(c0 + 1) % 256] && cl_a[(c0 + 1) % 256] == 6,
          "R5 media write after read", 64'(ncmd - c0), 2);
      chk(mem_m[6] == 2'd3 && mem_d[6][31:0] == 32'hA006, "R5 new meta stored, data kept",
          64'({mem_m[6], mem_d[6][31:0]}), 64'h3_0000A006);
      p0 = nrsp;
      send(1'b0, 6, '0, 2'd0, 2'd0);
      wait_rsp(p0);
      chk(rl_m[p0 % 256] == 2'd3, "R5 later read sees new meta", 64'(rl_m[p0 % 256]), 3);
   endtask

   task automatic t_youngest_fwd_update();
      int r0;
      med_lat = 25;
      r0 = nmrd;
      send(1'b1, 8, mkd(32'h8001), 2'd0, 2'd0);
      send(1'b1, 8, mkd(32'h8002), 2'd1, 2'd0);
      send(1'b0, 8, '0, 2'd0, 2'd2);
      chk(h_rsp_data[31:0] == 32'h8002 && h_rsp_meta == 2'd1, "R6 youngest write wins",
          64'({h_rsp_meta, h_rsp_data[31:0]}), 64'h1_00008002);
      drain();
      chk(nmrd == r0, "R6 no media read for hit", 64'(nmrd - r0), 0);
      chk(mem_d[8][31:0] == 32'h8002 && mem_m[8] == 2'd2, "R5 tag change on buffer hit",
          64'({mem_m[8], mem_d[8][31:0]}), 64'h2_00008002);
   endtask

   task automatic t_meta_opaque();
      int p0;
      med_lat = 2;
      send(1'b1, 40, mkd(32'h4040), 2'd3, 2'd0);
      send(1'b1, 41, mkd(32'h4141), 2'd0, 2'd0);
      drain();
      p0 = nrsp;
      send(1'b0, 40, '0, 2'd0, 2'd0);
      wait_rsp(p0);
      chk(rl_m[p0 % 256] == 2'd3, "R9 meta 3 returned", 64'(rl_m[p0 % 256]), 3);
      p0 = nrsp;
      send(1'b0, 41, '0, 2'd0, 2'd0);
      wait_rsp(p0);
      chk(rl_m[p0 % 256] == 2'd0, "R9 meta 0 returned", 64'(rl_m[p0 % 256]), 0);
   endtask

   task automatic t_capacity_order();
      int c0;
      med_lat = 1;
      drain();
      c0 = ncmd;
      @(negedge clk);
      med_rdy = 1'b0;
      for (int i = 0; i < 4; i++) send(1'b1, 10 + i, mkd(32'h1000 + i), 2'd1, 2'd0);
      chk(h_req_ready == 1'b0, "R7 ready low with full buffer", 64'(h_req_ready), 0);
      med_rdy = 1'b1;
      send(1'b1, 14, mkd(32'h1004), 2'd1, 2'd0);
      drain();
      for (int i = 0; i < 5; i++)
         chk(cl_wr[(c0 + i) % 256] && cl_a[(c0 + i) % 256] == AW'(10 + i),
             "R3 writes issued in order", 64'(cl_a[(c0 + i) % 256]), 64'(10 + i));
   endtask

   task automatic t_resp_order();
      int p0;
      med_lat = 3;
      p0 = nrsp;
      send(1'b1, 30, mkd(32'h3030), 2'd1, 2'd0);
      send(1'b0, 31, '0, 2'd0, 2'd0);
      send(1'b1, 32, mkd(32'h3232), 2'd2, 2'd0);
      send(1'b0, 30, '0, 2'd0, 2'd0);
      wait_rsp(p0 + 3);
      chk(rl_wr[p0 % 256] == 1'b1, "R8 first response is write", 64'(rl_wr[p0 % 256]), 1);
      chk(!rl_wr[(p0 + 1) % 256] && rl_d[(p0 + 1) % 256] == 32'hA01F
          && rl_m[(p0 + 1) % 256] == 2'd3, "R8 second response is read of 31",
          64'(rl_d[(p0 + 1) % 256]), 64'hA01F);
      chk(rl_wr[(p0 + 2) % 256] == 1'b1, "R8 third response is write",
          64'(rl_wr[(p0 + 2) % 256]), 1);
      chk(!rl_wr[(p0 + 3) % 256] && rl_d[(p0 + 3) % 256] == 32'h3030
          && rl_m[(p0 + 3) % 256] == 2'd1, "R8 fourth response is read of 30",
          64'(rl_d[(p0 + 3) % 256]), 64'h3030);
      repeat (5) @(negedge clk);
      chk(nrsp == p0 + 4, "R8 one response per request", 64'(nrsp - p0), 4);
      drain();
   endtask

   task automatic t_read_priority();
      int c0, p0;
      med_lat = 2;
      drain();
      c0 = ncmd; p0 = nrsp;
      @(negedge clk);
      med_rdy = 1'b0;
      send(1'b1, 20, mkd(32'h2020), 2'd1, 2'd0);
      send(1'b0, 21, '0, 2'd0, 2'd0);
      @(negedge clk);
      med_rdy = 1'b1;
      wait_rsp(p0 + 1);
      drain();
      chk(!cl_wr[c0 % 256] && cl_a[c0 % 256] == 21, "R10 read issued before write",
          64'({cl_wr[c0 % 256], cl_a[c0 % 256]}), 64'd21);
      chk(cl_wr[(c0 + 1) % 256] && cl_a[(c0 + 1) % 256] == 20, "R10 write issued after read",
          64'(cl_a[(c0 + 1) % 256]), 64'd20);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_early_cpl_and_fwd();
      t_read_plain();
      t_read_update();
      t_youngest_fwd_update();
      t_meta_opaque();
      t_capacity_order();
      t_resp_order();
      t_read_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule